// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block is a general-purpose I/O port with per-pin direction control. A host reaches it over a simple synchronous register bus. Each pin has an output-enable bit and an output data bit. Its input level passes through a synchronizer and is checked for rising and falling edges on every clock. Rising and falling edges have their own enable masks and their own sticky status registers. A host clears a status bit by writing a one to it. One registered interrupt line summarizes every status bit whose enable is set.

The register contents are big-endian. A little-endian host sets a swap bit in the control register, and the block then exchanges the bytes of each data word on both reads and writes. The control register itself is never swapped, so the swap bit can always be found and read back.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: Register word addresses are 0 control, 1 direction, 2 data-out, 3 data-in, 4 rising enable, 5 falling enable, 6 rising status and 7 falling status. Addresses 8 to 15 read zero. A read returns its data on `bus_rdata` one clock after it is accepted. Writes to data-in have no effect.
- R3: A 1 in a direction bit makes that pin an output. `pin_oe` follows the direction register and `pin_out` follows the data-out register.
- R4: Data-in returns the pin levels after a two-stage synchronizer. A read accepted in the first cycle after a pin changes still returns the old level. A read that follows that one returns the new level.
- R5: A rising edge on a pin sets only its rising status bit, and a falling edge sets only its falling status bit. The rising and falling enables act independently per pin.
- R6: An edge sets a status bit only when the matching enable bit is 1 in the cycle in which the edge is detected.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: When a qualifying edge and a write-one clear reach the same status bit in the same cycle, the bit stays set.
- R9: `irq` is a register holding the OR, over all pins, of (rising status AND rising enable) and (falling status AND falling enable). Clearing an enable lowers `irq` and keeps the status bit.
- R10: Control bit 0 is the swap bit. It is never byte-swapped and it reads back as written. While it is 1, the two bytes of every other register's data word exchange places on both writes and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid one clock after the read |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output data driven to pins |
| pin_oe | output | WIDTH | Per-pin output enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check the following on every cycle:
- a status bit falls only when a clear was written to it;
- a status bit rises only on a matching edge while the matching enable is set;
- an edge beats a clear in the same cycle;
- `irq` equals the enabled-status OR of the cycle before.

The bench's scenarios are the only check of these behaviours:
- the register decode;
- the one-cycle read latency and the synchronizer's delay as seen at the bus;
- the reset values;
- the byte order of every register when swap mode is on or off;
- that the control register is never swapped.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   // Word-address decode of the register file (low three address bits).
   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_DIR  = 3'd1,
      REG_DOUT = 3'd2,
      REG_DIN  = 3'd3,
      REG_REN  = 3'd4,
      REG_FEN  = 3'd5,
      REG_RST  = 3'd6,
      REG_FST  = 3'd7
   } gpio_reg_e;

   localparam int unsigned GPIO_REG_BITS = 3;
   localparam int unsigned GPIO_SWAP_BIT = 0;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   input  logic [W-1:0] en_rise,
   input  logic [W-1:0] en_fall,
   input  logic [W-1:0] clr_rise,
   input  logic [W-1:0] clr_fall,
   output logic [W-1:0] edge_rise,
   output logic [W-1:0] edge_fall,
   output logic [W-1:0] st_rise,
   output logic [W-1:0] st_fall
);

   for (genvar b = 0; b < int'(W); b++) begin : g_bit
      logic prev_q;
      logic rise_q;
      logic fall_q;
      logic up;
      logic down;

      assign up   =  level[b] & ~prev_q;
      assign down = ~level[b] &  prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
         end else begin
            prev_q <= level[b];
            // set term is ORed after the clear: a same-cycle edge wins
            rise_q <= (rise_q & ~clr_rise[b]) | (up   & en_rise[b]);
            fall_q <= (fall_q & ~clr_fall[b]) | (down & en_fall[b]);
         end
      end

      assign edge_rise[b] = up;
      assign edge_fall[b] = down;
      assign st_rise[b]   = rise_q;
      assign st_fall[b]   = fall_q;
   end

endmodule

// File: rtl/gpio_byte_swap.sv
module gpio_byte_swap #(
   parameter int unsigned W = 16
) (
   input  logic         swap_on,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   localparam int unsigned NBYTES = W / 8;

   logic [W-1:0] reversed;

   for (genvar k = 0; k < int'(NBYTES); k++) begin : g_byte
      assign reversed[8*k +: 8] = din[8*(NBYTES-1-k) +: 8];
   end

   assign dout = swap_on ? reversed : din;

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SWAP_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic              irq
);

   localparam int unsigned HI_BITS = ADDR_W - GPIO_REG_BITS;

   // ---------------- elaboration-time parameter checks ----------------
   if (WIDTH < 8) begin : g_bad_width
      $error("gpio_edge_port: WIDTH must be at least 8");
   end
   if (SWAP_EN && (WIDTH % 8 != 0)) begin : g_bad_swap
      $error("gpio_edge_port: byte swap needs WIDTH to be a whole number of bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_edge_port: SYNC_STAGES must be 2 or more");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("gpio_edge_port: ADDR_W must be at least 4");
   end

   // ---------------- bus decode ----------------
   logic      wr_acc;
   logic      rd_acc;
   logic      addr_hit;
   gpio_reg_e reg_sel;

   assign wr_acc   = bus_sel &  bus_we;
   assign rd_acc   = bus_sel & ~bus_we;
   assign addr_hit = (bus_addr[ADDR_W-1 -: HI_BITS] == '0);
   assign reg_sel  = gpio_reg_e'(bus_addr[GPIO_REG_BITS-1:0]);

   logic wr_ctrl, wr_dir, wr_dout, wr_ren, wr_fen, wr_rst, wr_fst;
   assign wr_ctrl = wr_acc & addr_hit & (reg_sel == REG_CTRL);
   assign wr_dir  = wr_acc & addr_hit & (reg_sel == REG_DIR);
   assign wr_dout = wr_acc & addr_hit & (reg_sel == REG_DOUT);
   assign wr_ren  = wr_acc & addr_hit & (reg_sel == REG_REN);
   assign wr_fen  = wr_acc & addr_hit & (reg_sel == REG_FEN);
   assign wr_rst  = wr_acc & addr_hit & (reg_sel == REG_RST);
   assign wr_fst  = wr_acc & addr_hit & (reg_sel == REG_FST);

   // ---------------- byte-order stage ----------------
   logic             swap_q;
   logic [WIDTH-1:0] wdata_int;
   logic [WIDTH-1:0] rd_core;
   logic [WIDTH-1:0] rd_bus;

   if (SWAP_EN) begin : g_swap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       swap_q <= 1'b0;
         else if (wr_ctrl) swap_q <= bus_wdata[GPIO_SWAP_BIT];
      end

      gpio_byte_swap #(.W(WIDTH)) u_wr_swap (
         .swap_on (swap_q),
         .din     (bus_wdata),
         .dout    (wdata_int)
      );

      gpio_byte_swap #(.W(WIDTH)) u_rd_swap (
         .swap_on (swap_q),
         .din     (rd_core),
         .dout    (rd_bus)
      );
   end else begin : g_noswap
      assign swap_q    = 1'b0;
      assign wdata_int = bus_wdata;
      assign rd_bus    = rd_core;
   end

   // ---------------- configuration registers ----------------
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] dout_q;
   logic [WIDTH-1:0] en_rise;
   logic [WIDTH-1:0] en_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         dout_q  <= '0;
         en_rise <= '0;
         en_fall <= '0;
      end else begin
         if (wr_dir)  dir_q   <= wdata_int;
         if (wr_dout) dout_q  <= wdata_int;
         if (wr_ren)  en_rise <= wdata_int;
         if (wr_fen)  en_fall <= wdata_int;
      end
   end

   assign pin_oe  = dir_q;
   assign pin_out = dout_q;

   // ---------------- input path ----------------
   logic [WIDTH-1:0] din_sync;

   gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (din_sync)
   );

   logic [WIDTH-1:0] clr_rise;
   logic [WIDTH-1:0] clr_fall;
   logic [WIDTH-1:0] edge_rise;
   logic [WIDTH-1:0] edge_fall;
   logic [WIDTH-1:0] st_rise;
   logic [WIDTH-1:0] st_fall;

   assign clr_rise = wr_rst ? wdata_int : '0;
   assign clr_fall = wr_fst ? wdata_int : '0;

   gpio_edge_unit #(.W(WIDTH)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .level     (din_sync),
      .en_rise   (en_rise),
      .en_fall   (en_fall),
      .clr_rise  (clr_rise),
      .clr_fall  (clr_fall),
      .edge_rise (edge_rise),
      .edge_fall (edge_fall),
      .st_rise   (st_rise),
      .st_fall   (st_fall)
   );

   // ---------------- interrupt ----------------
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |((st_rise & en_rise) | (st_fall & en_fall));
   end

   assign irq = irq_q;

   // ---------------- read path ----------------
   logic [WIDTH-1:0] ctrl_word;
   logic [WIDTH-1:0] rd_next;
   logic [WIDTH-1:0] rdata_q;

   assign ctrl_word = {{(WIDTH-1){1'b0}}, swap_q};

   always_comb begin
      unique case (reg_sel)
         REG_DIR:  rd_core = dir_q;
         REG_DOUT: rd_core = dout_q;
         REG_DIN:  rd_core = din_sync;
         REG_REN:  rd_core = en_rise;
         REG_FEN:  rd_core = en_fall;
         REG_RST:  rd_core = st_rise;
         REG_FST:  rd_core = st_fall;
         default:  rd_core = '0;
      endcase
   end

   always_comb begin
      if (!addr_hit)                rd_next = '0;
      else if (reg_sel == REG_CTRL) rd_next = ctrl_word;
      else                          rd_next = rd_bus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_acc) rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         irq,
   input logic [W-1:0] st_rise,
   input logic [W-1:0] st_fall,
   input logic [W-1:0] en_rise,
   input logic [W-1:0] en_fall,
   input logic [W-1:0] edge_rise,
   input logic [W-1:0] edge_fall,
   input logic [W-1:0] clr_rise,
   input logic [W-1:0] clr_fall
);

   // R7: a status bit only drops when a one was written to it
   a_r7_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(st_rise) & ~st_rise & ~$past(clr_rise)) |
       ($past(st_fall) & ~st_fall & ~$past(clr_fall))) == '0);

   // R5: each status register only rises on its own edge direction
   a_r5_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_rise & ~$past(st_rise) & ~$past(edge_rise)) |
       (st_fall & ~$past(st_fall) & ~$past(edge_fall))) == '0);

   // R6: no status bit rises while its enable was clear
   a_r6_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_rise & ~$past(st_rise) & ~$past(en_rise)) |
       (st_fall & ~$past(st_fall) & ~$past(en_fall))) == '0);

   // R8: qualifying edge coincident with a clear leaves the bit set
   a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((~st_rise & $past(edge_rise & en_rise & clr_rise)) |
       (~st_fall & $past(edge_fall & en_fall & clr_fall))) == '0);

   // R9: irq reflects the enabled status of the previous cycle
   a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|((st_rise & en_rise) | (st_fall & en_fall))));

endmodule

bind gpio_edge_port gpio_edge_chk #(.W(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .st_rise   (st_rise),
   .st_fall   (st_fall),
   .en_rise   (en_rise),
   .en_fall   (en_fall),
   .edge_rise (edge_rise),
   .edge_fall (edge_fall),
   .clr_rise  (clr_rise),
   .clr_fall  (clr_fall)
);

// File: tb/sim_gpio_edge_port.sv
module sim_gpio_edge_port;

   localparam logic [3:0] A_CTRL = 4'd0;
   localparam logic [3:0] A_DIR  = 4'd1;
   localparam logic [3:0] A_DOUT = 4'd2;
   localparam logic [3:0] A_DIN  = 4'd3;
   localparam logic [3:0] A_REN  = 4'd4;
   localparam logic [3:0] A_FEN  = 4'd5;
   localparam logic [3:0] A_RST  = 4'd6;
   localparam logic [3:0] A_FST  = 4'd7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] pin_in = '0;
   wire  [15:0] bus_rdata;
   wire  [15:0] pin_out;
   wire  [15:0] pin_oe;
   wire         irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   gpio_edge_port u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   function automatic logic [15:0] bswap(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic brd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setpin(input logic [15:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1 irq", {15'b0, irq}, 16'h0);
      chk("R1 pin_oe", pin_oe, 16'h0);
      chk("R1 pin_out", pin_out, 16'h0);
      for (int a = 0; a < 8; a++) begin
         brd(4'(a), r);
         chk("R1 register", r, 16'h0);
      end

      // R2 unused addresses and read-only data-in
      for (int a = 8; a < 16; a++) begin
         brd(4'(a), r);
         chk("R2 unused address", r, 16'h0);
      end
      bwr(A_DIN, 16'hFFFF);
      brd(A_DIN, r);
      chk("R2 din write ignored", r, 16'h0);

      // R10 control readback
      bwr(A_CTRL, 16'h0001);
      brd(A_CTRL, r);
      chk("R10 ctrl set", r, 16'h0001);
      bwr(A_CTRL, 16'h0000);
      brd(A_CTRL, r);
      chk("R10 ctrl clear", r, 16'h0000);

      // R3 direction and data-out walking patterns
      for (int i = 0; i < 16; i++) begin
         bwr(A_DIR, 16'(1 << i));
         chk("R3 pin_oe", pin_oe, 16'(1 << i));
         brd(A_DIR, r);
         chk("R3 dir readback", r, 16'(1 << i));
         bwr(A_DOUT, ~16'(1 << i));
         chk("R3 pin_out", pin_out, ~16'(1 << i));
         brd(A_DOUT, r);
         chk("R3 dout readback", r, ~16'(1 << i));
      end

      // R4 synchronizer latency and data-in patterns
      for (int i = 0; i < 16; i++) begin
         logic [15:0] prev_v, v;
         prev_v = pin_in;
         v = 16'(1 << i) ^ 16'hA5A5;
         setpin(v);
         brd(A_DIN, r);
         chk("R4 din old level", r, prev_v);
         brd(A_DIN, r);
         chk("R4 din new level", r, v);
      end
      setpin(16'h0);
      idle(4);

      // R5 R6 R7 R9 per-pin edge handling
      for (int i = 0; i < 16; i++) begin
         logic [15:0] m;
         m = 16'(1 << i);
         bwr(A_REN, m);
         bwr(A_FEN, 16'h0);
         setpin(m); idle(4);
         brd(A_RST, r); chk("R5 rise status", r, m);
         brd(A_FST, r); chk("R5 no fall status on rise", r, 16'h0);
         chk("R9 irq on rise", {15'b0, irq}, 16'h1);
         setpin(16'h0); idle(4);
         brd(A_FST, r); chk("R6 fall not enabled", r, 16'h0);
         bwr(A_RST, 16'h0);
         brd(A_RST, r); chk("R7 write zero keeps", r, m);
         bwr(A_RST, m);
         brd(A_RST, r); chk("R7 write one clears", r, 16'h0);
         idle(2);
         chk("R9 irq after clear", {15'b0, irq}, 16'h0);

         bwr(A_REN, 16'h0);
         bwr(A_FEN, m);
         setpin(m); idle(4);
         brd(A_RST, r); chk("R6 rise not enabled", r, 16'h0);
         chk("R9 no irq", {15'b0, irq}, 16'h0);
         setpin(16'h0); idle(4);
         brd(A_FST, r); chk("R5 fall status", r, m);
         brd(A_RST, r); chk("R5 no rise status on fall", r, 16'h0);
         chk("R9 irq on fall", {15'b0, irq}, 16'h1);
         bwr(A_FST, m);
         brd(A_FST, r); chk("R7 fall clear", r, 16'h0);
         idle(2);
      end

      // R5 all pins at once
      bwr(A_FEN, 16'h0);
      bwr(A_REN, 16'hFFFF);
      setpin(16'hFFFF); idle(4);
      brd(A_RST, r); chk("R5 all pins rise", r, 16'hFFFF);
      bwr(A_RST, 16'hFFFF);
      setpin(16'h0); idle(4);

      // R9 dropping the enable lowers irq, status kept
      bwr(A_REN, 16'hFFFF);
      setpin(16'h0008); idle(4);
      chk("R9 irq raised", {15'b0, irq}, 16'h1);
      bwr(A_REN, 16'h0);
      idle(2);
      chk("R9 irq drops with enable", {15'b0, irq}, 16'h0);
      brd(A_RST, r); chk("R9 status kept", r, 16'h0008);
      bwr(A_RST, 16'hFFFF);
      setpin(16'h0); idle(4);

      // R8 edge coincident with clear
      bwr(A_REN, 16'h0020);
      setpin(16'h0020); idle(4);
      setpin(16'h0000); idle(4);
      brd(A_RST, r); chk("R8 precondition", r, 16'h0020);
      setpin(16'h0020);
      @(negedge clk);
      bwr(A_RST, 16'h0020);
      brd(A_RST, r); chk("R8 edge beats clear", r, 16'h0020);
      bwr(A_RST, 16'h0020);
      brd(A_RST, r); chk("R8 later clear works", r, 16'h0000);
      setpin(16'h0); idle(4);
      bwr(A_REN, 16'h0);

      // R10 swap mode
      bwr(A_CTRL, 16'h0001);
      brd(A_CTRL, r); chk("R10 ctrl unswapped", r, 16'h0001);
      bwr(A_DIR, 16'h1234);
      chk("R10 swapped write", pin_oe, bswap(16'h1234));
      brd(A_DIR, r); chk("R10 swapped readback", r, 16'h1234);
      bwr(A_DOUT, 16'h00FF);
      chk("R10 swapped dout", pin_out, 16'hFF00);
      setpin(16'hABCD); idle(4);
      brd(A_DIN, r); chk("R10 swapped din", r, 16'hCDAB);
      setpin(16'h0); idle(4);
      bwr(A_REN, 16'h0001);
      setpin(16'h0100); idle(4);
      brd(A_RST, r); chk("R10 swapped status", r, 16'h0001);
      bwr(A_RST, 16'h0001);
      brd(A_RST, r); chk("R10 swapped clear", r, 16'h0000);
      bwr(A_CTRL, 16'h0000);
      brd(A_DIR, r); chk("R10 swap off again", r, 16'h3412);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule